// File: doc/BRIEF.md
# Neighbor Tag Miss Predictor

A direct-mapped DRAM cache that stores each line's tag beside its data returns, with every demand read, the tag of the adjacent line in the same DRAM row. That extra tag costs no additional bandwidth. This block keeps those tags in a small buffer for each cache bank. When a later request arrives for the adjacent set, the buffer can often give the answer straight away. If the stored tag differs from the requested tag, the line is absent and the request can go directly to main memory without a tag probe of the DRAM cache. If the stored tag equals the requested tag, the line is present. With no entry for the set, the answer is unknown and the normal probe runs.

Each bank buffer holds a small number of entries. Each entry has a valid bit, a set index and a tag. New entries are allocated in round-robin order. Fills and writeback-fills pass through an update port, which rewrites the tag of any entry for that set, so a tag that is out of date is never used to declare a miss. The query answer is combinational from the stored state.

Top module: `ntb_top`

## Requirements
- R1: After reset, every query answers unknown (code 2'b00) for every bank and set.
- R2: A capture with bank b, set s and tag t stores t for set s^1, the neighbor (index differs only in bit 0), in bank b. From the next cycle, a query to bank b, set s^1 with a tag other than t answers miss (code 2'b01).
- R3: A query whose bank and set have a stored entry with an equal tag answers hit (code 2'b10).
- R4: A query whose set has no valid entry in the queried bank answers unknown. This applies to the captured demand set itself and to the same set in any other bank.
- R5: A capture for a neighbor set that already has an entry in that bank rewrites that entry's tag and allocates no new entry.
- R6: With ENTRIES entries per bank (default 4), the first allocation after reset uses entry 0. Each further allocation takes the next entry in circular order, so the (ENTRIES+1)th distinct set evicts the oldest allocation.
- R7: An update with bank b, set s and tag t rewrites the tag of an existing entry for set s in bank b to t. An update to a set with no entry allocates nothing.
- R8: If a capture and an update in the same cycle target the same bank and the same stored set, the update wins. The capture is dropped and, when there is no entry, the set stays unknown.
- R9: The query answer reflects the state after the last clock edge. A capture or update takes effect from the following cycle.
- R10: A capture or update with its valid input low leaves the stored state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_valid_i | input | 1 | Capture request valid |
| cap_bank_i | input | BANK_W | Bank of the demand access |
| cap_set_i | input | SET_W | Demand set index; the neighbor is this index with bit 0 flipped |
| cap_tag_i | input | TAG_W | Tag of the neighbor line |
| upd_valid_i | input | 1 | Fill or writeback-fill valid |
| upd_bank_i | input | BANK_W | Bank being filled |
| upd_set_i | input | SET_W | Set being filled |
| upd_tag_i | input | TAG_W | New resident tag |
| qry_valid_i | input | 1 | Query valid |
| qry_bank_i | input | BANK_W | Bank of the query |
| qry_set_i | input | SET_W | Set of the query |
| qry_tag_i | input | TAG_W | Requested tag |
| qry_res_o | output | 2 | 00 unknown, 01 miss, 10 hit |

## Verification
Directed sequences on one bank work through the three answers. They separate the neighbor set from the demand set and from other banks. They also tell rewrite-in-place apart from allocation by filling all entries and then forcing one eviction. They tell an update of an existing entry apart from an update to an absent set, and they cover capture/update collisions both with and without an existing entry. A seeded random phase then confines traffic to four banks, sixteen sets and four tags, so hits, misses, evictions and collisions are all frequent. Every query is compared with a bench model of the allocation rules.

// File: rtl/ntb_pkg.sv
package ntb_pkg;
  typedef enum logic [1:0] {
    RES_UNKNOWN = 2'b00,
    RES_MISS    = 2'b01,
    RES_HIT     = 2'b10
  } ntb_res_e;
endpackage

// File: rtl/ntb_lookup.sv
module ntb_lookup #(
  parameter int ENTRIES = 4,
  parameter int SET_W   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][SET_W-1:0] sets_i,
  input  logic [SET_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_o[e] = valid_i[e] && (sets_i[e] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_o[e]) idx_o = IDX_W'(e);
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/ntb_rr_ptr.sv
module ntb_rr_ptr #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && ptr_o != LAST) |=> ptr_o == $past(ptr_o) + 1'b1);
endmodule

// File: rtl/ntb_bank.sv
module ntb_bank
  import ntb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int SET_W   = 16,
  parameter int TAG_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [SET_W-1:0] cap_set_i,
  input  logic [TAG_W-1:0] cap_tag_i,
  input  logic             upd_en_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic [SET_W-1:0] qry_set_i,
  input  logic [TAG_W-1:0] qry_tag_i,
  output ntb_res_e         qry_res_o
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][SET_W-1:0] set_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;

  logic [SET_W-1:0]   nbr_set;
  logic [ENTRIES-1:0] cap_match, upd_match, qry_match;
  logic               cap_hit, upd_hit, qry_hit;
  logic [IDX_W-1:0]   cap_idx, upd_idx, qry_idx, rr_ptr;
  logic               collide, cap_go, alloc;
  logic [IDX_W-1:0]   cap_widx;

  assign nbr_set = {cap_set_i[SET_W-1:1], ~cap_set_i[0]};

  ntb_lookup #(.ENTRIES(ENTRIES), .SET_W(SET_W)) u_cap_lu (
    .valid_i(valid_q), .sets_i(set_q), .key_i(nbr_set),
    .match_o(cap_match), .hit_o(cap_hit), .idx_o(cap_idx));
  ntb_lookup #(.ENTRIES(ENTRIES), .SET_W(SET_W)) u_upd_lu (
    .valid_i(valid_q), .sets_i(set_q), .key_i(upd_set_i),
    .match_o(upd_match), .hit_o(upd_hit), .idx_o(upd_idx));
  ntb_lookup #(.ENTRIES(ENTRIES), .SET_W(SET_W)) u_qry_lu (
    .valid_i(valid_q), .sets_i(set_q), .key_i(qry_set_i),
    .match_o(qry_match), .hit_o(qry_hit), .idx_o(qry_idx));

  // update wins over a capture aimed at the same set
  assign collide  = cap_en_i && upd_en_i && (nbr_set == upd_set_i);
  assign cap_go   = cap_en_i && !collide;
  assign alloc    = cap_go && !cap_hit;
  assign cap_widx = cap_hit ? cap_idx : rr_ptr;

  ntb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(alloc), .ptr_o(rr_ptr));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic cap_we, upd_we;
    assign cap_we = cap_go && (cap_widx == IDX_W'(e));
    assign upd_we = upd_en_i && upd_hit && (upd_idx == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        set_q[e]   <= '0;
        tag_q[e]   <= '0;
      end else if (cap_we) begin
        valid_q[e] <= 1'b1;
        set_q[e]   <= nbr_set;
        tag_q[e]   <= cap_tag_i;
      end else if (upd_we) begin
        tag_q[e]   <= upd_tag_i;
      end
    end
  end

  always_comb begin
    if (!qry_hit)                     qry_res_o = RES_UNKNOWN;
    else if (tag_q[qry_idx] == qry_tag_i) qry_res_o = RES_HIT;
    else                              qry_res_o = RES_MISS;
  end

  a_r5_unique_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(qry_match));
  a_r7_upd_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_hit && !(cap_go && cap_widx == upd_idx))
      |=> tag_q[$past(upd_idx)] == $past(upd_tag_i));
  a_r8_collide_no_valid_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide |=> $stable(valid_q));
  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !upd_en_i) |=> ($stable(valid_q) && $stable(tag_q) && $stable(set_q)));
endmodule

// File: rtl/ntb_top.sv
module ntb_top
  import ntb_pkg::*;
#(
  parameter int NUM_BANKS = 64,
  parameter int ENTRIES   = 4,
  parameter int SET_W     = 16,
  parameter int TAG_W     = 12,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_valid_i,
  input  logic [BANK_W-1:0] cap_bank_i,
  input  logic [SET_W-1:0]  cap_set_i,
  input  logic [TAG_W-1:0]  cap_tag_i,
  input  logic              upd_valid_i,
  input  logic [BANK_W-1:0] upd_bank_i,
  input  logic [SET_W-1:0]  upd_set_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic              qry_valid_i,
  input  logic [BANK_W-1:0] qry_bank_i,
  input  logic [SET_W-1:0]  qry_set_i,
  input  logic [TAG_W-1:0]  qry_tag_i,
  output logic [1:0]        qry_res_o
);
  ntb_res_e bank_res [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ntb_bank #(.ENTRIES(ENTRIES), .SET_W(SET_W), .TAG_W(TAG_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_en_i  (cap_valid_i && (cap_bank_i == BANK_W'(b))),
      .cap_set_i (cap_set_i),
      .cap_tag_i (cap_tag_i),
      .upd_en_i  (upd_valid_i && (upd_bank_i == BANK_W'(b))),
      .upd_set_i (upd_set_i),
      .upd_tag_i (upd_tag_i),
      .qry_set_i (qry_set_i),
      .qry_tag_i (qry_tag_i),
      .qry_res_o (bank_res[b])
    );
  end

  always_comb begin
    qry_res_o = RES_UNKNOWN;
    if (qry_valid_i && (int'(qry_bank_i) < NUM_BANKS)) qry_res_o = bank_res[qry_bank_i];
  end

  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_res_o != 2'b11);
endmodule

// File: tb/ntb_top_test.sv
module ntb_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64, NE = 4, SW = 16, TW = 12, BW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_v = 0, upd_v = 0, qry_v = 0;
  logic [BW-1:0] cap_b = 0, upd_b = 0, qry_b = 0;
  logic [SW-1:0] cap_s = 0, upd_s = 0, qry_s = 0;
  logic [TW-1:0] cap_t = 0, upd_t = 0, qry_t = 0;
  logic [1:0] res;

  always #(CLK_PERIOD/2) clk = ~clk;

  ntb_top #(.NUM_BANKS(NB), .ENTRIES(NE), .SET_W(SW), .TAG_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cap_valid_i(cap_v), .cap_bank_i(cap_b), .cap_set_i(cap_s), .cap_tag_i(cap_t),
    .upd_valid_i(upd_v), .upd_bank_i(upd_b), .upd_set_i(upd_s), .upd_tag_i(upd_t),
    .qry_valid_i(qry_v), .qry_bank_i(qry_b), .qry_set_i(qry_s), .qry_tag_i(qry_t),
    .qry_res_o(res));

  bit          m_v [NB][NE];
  logic [SW-1:0] m_s [NB][NE];
  logic [TW-1:0] m_t [NB][NE];
  int          m_p [NB];
  int n_chk = 0, n_bad = 0;

  function automatic int find(int b, logic [SW-1:0] s);
    for (int e = 0; e < NE; e++) if (m_v[b][e] && m_s[b][e] == s) return e;
    return -1;
  endfunction

  function automatic logic [1:0] model_q(int b, logic [SW-1:0] s, logic [TW-1:0] t);
    int e = find(b, s);
    if (e < 0) return 2'b00;
    return (m_t[b][e] == t) ? 2'b10 : 2'b01;
  endfunction

  function automatic void model_step(bit cv, int cb, logic [SW-1:0] cs, logic [TW-1:0] ct,
                                     bit uv, int ub, logic [SW-1:0] us, logic [TW-1:0] ut);
    logic [SW-1:0] ns = cs ^ SW'(1);
    bit clash = cv && uv && cb == ub && ns == us;
    if (uv) begin
      int e = find(ub, us);
      if (e >= 0) m_t[ub][e] = ut;
    end
    if (cv && !clash) begin
      int e = find(cb, ns);
      if (e < 0) begin
        e = m_p[cb];
        m_p[cb] = (m_p[cb] + 1) % NE;
      end
      m_v[cb][e] = 1; m_s[cb][e] = ns; m_t[cb][e] = ct;
    end
  endfunction

  // exp < 0: compare with model; otherwise with the given constant
  task automatic step(input string rq, input int exp,
                      input bit cv, input int cb, input int cs, input int ct,
                      input bit uv, input int ub, input int us, input int ut,
                      input bit qv, input int qb, input int qs, input int qt);
    logic [1:0] e;
    @(negedge clk);
    cap_v = cv; cap_b = BW'(cb); cap_s = SW'(cs); cap_t = TW'(ct);
    upd_v = uv; upd_b = BW'(ub); upd_s = SW'(us); upd_t = TW'(ut);
    qry_v = qv; qry_b = BW'(qb); qry_s = SW'(qs); qry_t = TW'(qt);
    #1;
    if (qv) begin
      e = (exp < 0) ? model_q(qb, SW'(qs), TW'(qt)) : 2'(exp);
      n_chk++;
      if (res !== e) begin
        n_bad++;
        $display("FAIL %s bank=%0d set=%0d tag=%0d actual=%b expected=%b", rq, qb, qs, qt, res, e);
      end
    end
    model_step(cv, cb, SW'(cs), TW'(ct), uv, ub, SW'(us), TW'(ut));
  endtask

  task automatic q(input string rq, input int exp, input int b, input int s, input int t);
    step(rq, exp, 0, 0, 0, 0, 0, 0, 0, 0, 1, b, s, t);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin
      m_p[b] = 0;
      for (int e = 0; e < NE; e++) begin m_v[b][e] = 0; m_s[b][e] = '0; m_t[b][e] = '0; end
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    q("R1", 0, 3, 5, 1);
    q("R1", 0, 0, 0, 0);
    q("R1", 0, 63, 11, 7);
    // R2 capture of set 10 stores neighbor 11; same-cycle query not yet visible (R9)
    step("R9", 0, 1, 3, 10, 'h55, 0, 0, 0, 0, 1, 3, 11, 'h55);
    q("R2", 1, 3, 11, 'h66);
    q("R3", 2, 3, 11, 'h55);
    q("R4", 0, 3, 10, 'h55);
    q("R4", 0, 4, 11, 'h55);
    // R5 rewrite in place
    step("R5", -1, 1, 3, 10, 'h77, 0, 0, 0, 0, 0, 0, 0, 0);
    q("R5", 2, 3, 11, 'h77);
    step("R6", -1, 1, 3, 20, 'h21, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", -1, 1, 3, 30, 'h31, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", -1, 1, 3, 40, 'h41, 0, 0, 0, 0, 0, 0, 0, 0);
    q("R5", 2, 3, 11, 'h77);
    // R6 fifth distinct set evicts entry 0 (set 11)
    step("R6", -1, 1, 3, 50, 'h51, 0, 0, 0, 0, 0, 0, 0, 0);
    q("R6", 0, 3, 11, 'h77);
    q("R6", 2, 3, 21, 'h21);
    q("R6", 2, 3, 51, 'h51);
    // R7 update existing / absent
    step("R7", -1, 0, 0, 0, 0, 1, 3, 21, 'h99, 0, 0, 0, 0);
    q("R7", 2, 3, 21, 'h99);
    q("R7", 1, 3, 21, 'h21);
    step("R7", -1, 0, 0, 0, 0, 1, 3, 60, 1, 0, 0, 0, 0);
    q("R7", 0, 3, 60, 1);
    // R8 collisions
    step("R8", -1, 1, 3, 30, 'hAA, 1, 3, 31, 'hBB, 0, 0, 0, 0);
    q("R8", 2, 3, 31, 'hBB);
    step("R8", -1, 1, 3, 70, 1, 1, 3, 71, 2, 0, 0, 0, 0);
    q("R8", 0, 3, 71, 1);
    q("R8", 2, 3, 41, 'h41);
    // R10 valid low ignored
    step("R10", -1, 0, 3, 40, 3, 0, 3, 41, 5, 1, 3, 41, 'h41);
    q("R10", 2, 3, 41, 'h41);

    // random phase (R9 against model)
    for (int i = 0; i < 3000; i++) begin
      step("R9", -1,
           bit'($urandom % 2), int'($urandom % 4), int'($urandom % 16), int'($urandom % 4),
           bit'($urandom % 3 == 0), int'($urandom % 4), int'($urandom % 16), int'($urandom % 4),
           1, int'($urandom % 4), int'($urandom % 16), int'($urandom % 4));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule